// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block is the device side of a three-wire serial EEPROM command port. A host drives chip select, a serial clock and a serial data line. The block samples all of them with a fast system clock and finds the leading start bit. It then decodes a two-bit opcode, an address field and, for programming commands, a data field. Read, single-word write, single-word erase, erase of the whole array, write of the whole array, and the write-enable and write-disable commands act on an internal register array.

A single data-out line, qualified by an output-enable for a tri-state pad, carries read data. The same line also carries a ready/busy flag while a self-timed programming cycle runs. The cycle length is a parameter counted in system clocks. An organization input selects 8-bit or 16-bit words over the same storage. A program-enable input must be high for the two data-carrying programming commands to take effect.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is high, serial clock rising edges with data-in low are ignored. The first rising edge with chip select and data-in both high is taken as the start bit.
- R2: The two bits after the start bit, first bit as MSB, select the command: 10 read, 01 write, 11 erase. For 00, the two most significant address bits select the command instead: 11 enables programming, 00 disables it, 10 erases the whole array, 01 writes the whole array. The other address bits are ignored.
- R3: With the organization input high, the address is ADDR16_W bits and the data is 16 bits. With it low, the address is ADDR16_W+1 bits and the data is 8 bits. In 8-bit mode, byte address a maps to 16-bit word a>>1: bit 0 of a equal to 0 selects bits 7:0 of that word and 1 selects bits 15:8. All fields are sent MSB first.
- R4: After reset the write-enable latch is clear and erase and write commands of every kind start no programming. An enable command sets the latch, which holds until a disable command clears it.
- R5: Read works whatever the latch state. On the clock edge that carries the last address bit, data-out is enabled and drives 0. Each later rising edge drives the next data bit, MSB first.
- R6: While chip select stays high after a word has been read, the following words come out in address order with no dummy bit. The address wraps from the top address to 0.
- R7: Erase sets every bit of the addressed word to 1. Erase-all sets every bit of the array to 1. Write-all stores the given data in every word; in 8-bit mode that means every byte.
- R8: Programming starts on the edge of the last data bit, or of the last address bit for erase and erase-all. It is busy for exactly PROG_CYC system clocks and finishes even if chip select falls.
- R9: A start bit or command received while programming is busy is ignored.
- R10: After programming has started, a rise of chip select following a low period enables data-out, which drives 0 while busy and 1 when ready. A new start bit removes this indication. Chip select low disables data-out, and after reset data-out is disabled.
- R11: Write and write-all take effect only if program-enable is high at the edge of the last data bit.
- R12: Chip select going low abandons a partly received command, which then has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock from the host, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| org_i | input | 1 | Word organization: 1 selects 16-bit, 0 selects 8-bit |
| pe_i | input | 1 | Program enable for write and write-all |
| do_o | output | 1 | Serial data out / ready-busy flag |
| do_oe | output | 1 | Output enable for data-out; 0 means high impedance |

## Verification
The hardest state to reach from the ports is a command that arrives while a self-timed cycle is still running. The bench makes PROG_CYC long compared with one serial command. Right after starting a write, it reads the busy flag and then sends a complete second write, all before the timer expires. A read afterwards shows that the second write left no trace. The bench also polls the flag until it reads ready and then sends a lone start bit, which must switch the flag off. Whole-array sweeps in both organizations, with wrapping sequential reads, cover the byte-lane mapping.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_DAT,
      ST_RD,
      ST_DONE
   } mw_state_e;

   typedef enum logic [2:0] {
      PG_NONE,
      PG_WORD,
      PG_ERASE,
      PG_ERAL,
      PG_WRAL
   } mw_prog_e;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_ERASE = 2'b11;
   localparam logic [1:0] OPC_EXT   = 2'b00;

   localparam logic [1:0] SUB_WEN   = 2'b11;
   localparam logic [1:0] SUB_WDIS  = 2'b00;
   localparam logic [1:0] SUB_ERAL  = 2'b10;
   localparam logic [1:0] SUB_WRAL  = 2'b01;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mw_sync needs at least two stages");
   end

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
   parameter int PROG_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic busy_o
);

   localparam int TW = $clog2(PROG_CYC + 1);

   logic [TW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             left_q <= '0;
      else if (go_i)          left_q <= TW'(PROG_CYC);
      else if (left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign busy_o = (left_q != '0);

endmodule

// File: rtl/mw_store.sv
module mw_store
   import mw_pkg::*;
#(
   parameter int ADDR16_W = 10
) (
   input  logic                clk,
   input  logic                go_i,
   input  mw_prog_e            kind_i,
   input  logic [ADDR16_W:0]   wa_i,
   input  logic [15:0]         wd_i,
   input  logic                worg_i,
   input  logic [ADDR16_W:0]   ra_i,
   input  logic                rorg_i,
   output logic [15:0]         rq_o
);

   localparam int WORDS = 1 << ADDR16_W;
   localparam int A8W   = ADDR16_W + 1;

   logic [WORDS*16-1:0]  flat;
   logic [ADDR16_W-1:0]  w_idx;
   logic                 w_hi;
   logic [15:0]          w_val;
   logic [ADDR16_W-1:0]  r_idx;
   logic [15:0]          r_word;

   // word index and byte lane of the programming target
   assign w_idx = worg_i ? wa_i[ADDR16_W-1:0] : wa_i[A8W-1:1];
   assign w_hi  = ~worg_i & wa_i[0];
   assign w_val = (kind_i == PG_ERASE) ? 16'hFFFF : wd_i;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [15:0] word_q;
      logic        hit;

      assign hit = (w_idx == ADDR16_W'(w));

      always_ff @(posedge clk) begin
         if (go_i) begin
            case (kind_i)
               PG_ERAL: word_q <= 16'hFFFF;
               PG_WRAL: word_q <= worg_i ? wd_i : {wd_i[7:0], wd_i[7:0]};
               PG_WORD, PG_ERASE: begin
                  if (hit) begin
                     if (worg_i)    word_q       <= w_val;
                     else if (w_hi) word_q[15:8] <= w_val[7:0];
                     else           word_q[7:0]  <= w_val[7:0];
                  end
               end
               default: ;
            endcase
         end
      end

      assign flat[w*16 +: 16] = word_q;
   end

   assign r_idx  = rorg_i ? ra_i[ADDR16_W-1:0] : ra_i[A8W-1:1];
   assign r_word = flat[r_idx*16 +: 16];

   // 8-bit reads are left aligned so the shifter always starts at bit 15
   assign rq_o = rorg_i ? r_word
               : (ra_i[0] ? {r_word[15:8], 8'h00} : {r_word[7:0], 8'h00});

endmodule

// File: rtl/mw_cmd_ctrl.sv
module mw_cmd_ctrl
   import mw_pkg::*;
#(
   parameter int ADDR16_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_s,
   input  logic                sk_rise,
   input  logic                di_s,
   input  logic                org_s,
   input  logic                pe_s,
   input  logic                busy_i,
   input  logic [15:0]         rq_i,
   output logic [ADDR16_W:0]   ra_o,
   output logic                rorg_o,
   output logic                pg_go_o,
   output mw_prog_e            pg_kind_o,
   output logic [ADDR16_W:0]   pg_addr_o,
   output logic [15:0]         pg_data_o,
   output logic                pg_org_o,
   output logic                rd_oe_o,
   output logic                rd_bit_o,
   output logic                show_o,
   output logic                wen_o
);

   localparam int A8W = ADDR16_W + 1;
   localparam int CW  = $clog2((A8W > 16) ? A8W : 16) + 1;

   mw_state_e       st_q;
   logic [CW-1:0]   cnt_q;
   logic [1:0]      op_q;
   logic [A8W-1:0]  addr_q;
   logic [15:0]     data_q;
   logic            org_q;
   logic            wen_q;
   logic [15:0]     sr_q;
   logic            cs_q;
   logic            pend_q;

   logic [A8W-1:0]  addr_n;
   logic [A8W-1:0]  addr_inc;
   logic [15:0]     data_n;
   logic [1:0]      sub;
   logic [CW-1:0]   a_last;
   logic [CW-1:0]   d_last;

   assign addr_n = {addr_q[A8W-2:0], di_s};
   assign data_n = {data_q[14:0], di_s};
   assign sub    = org_q ? addr_n[ADDR16_W-1 -: 2] : addr_n[A8W-1 -: 2];
   assign a_last = org_q ? CW'(ADDR16_W - 1) : CW'(A8W - 1);
   assign d_last = org_q ? CW'(15) : CW'(7);

   always_comb begin
      if (org_q) addr_inc = {1'b0, addr_q[ADDR16_W-1:0] + 1'b1};
      else       addr_inc = addr_q + 1'b1;
   end

   assign ra_o   = (st_q == ST_ADR) ? addr_n : addr_inc;
   assign rorg_o = org_q;
   assign wen_o  = wen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         op_q      <= '0;
         addr_q    <= '0;
         data_q    <= '0;
         org_q     <= 1'b0;
         wen_q     <= 1'b0;
         sr_q      <= '0;
         cs_q      <= 1'b0;
         pend_q    <= 1'b0;
         show_o    <= 1'b0;
         rd_oe_o   <= 1'b0;
         rd_bit_o  <= 1'b0;
         pg_go_o   <= 1'b0;
         pg_kind_o <= PG_NONE;
         pg_addr_o <= '0;
         pg_data_o <= '0;
         pg_org_o  <= 1'b0;
      end else begin
         pg_go_o <= 1'b0;
         cs_q    <= cs_s;
         if (!cs_s) begin
            st_q    <= ST_IDLE;
            rd_oe_o <= 1'b0;
            show_o  <= 1'b0;
         end else begin
            if (!cs_q) show_o <= pend_q;
            if (sk_rise) begin
               case (st_q)
                  ST_IDLE: begin
                     if (di_s && !busy_i) begin
                        st_q   <= ST_OPC;
                        cnt_q  <= '0;
                        addr_q <= '0;
                        data_q <= '0;
                        org_q  <= org_s;
                        pend_q <= 1'b0;
                        show_o <= 1'b0;
                     end
                  end
                  ST_OPC: begin
                     op_q  <= {op_q[0], di_s};
                     cnt_q <= cnt_q + 1'b1;
                     if (cnt_q == CW'(1)) begin
                        st_q  <= ST_ADR;
                        cnt_q <= '0;
                     end
                  end
                  ST_ADR: begin
                     addr_q <= addr_n;
                     cnt_q  <= cnt_q + 1'b1;
                     if (cnt_q == a_last) begin
                        cnt_q     <= '0;
                        st_q      <= ST_DONE;
                        pg_addr_o <= addr_n;
                        pg_org_o  <= org_q;
                        case (op_q)
                           OPC_READ: begin
                              st_q     <= ST_RD;
                              sr_q     <= rq_i;
                              rd_bit_o <= 1'b0;
                              rd_oe_o  <= 1'b1;
                           end
                           OPC_WRITE: st_q <= ST_DAT;
                           OPC_ERASE: begin
                              if (wen_q) begin
                                 pg_go_o   <= 1'b1;
                                 pg_kind_o <= PG_ERASE;
                                 pend_q    <= 1'b1;
                              end
                           end
                           default: begin
                              case (sub)
                                 SUB_WEN:  wen_q <= 1'b1;
                                 SUB_WDIS: wen_q <= 1'b0;
                                 SUB_ERAL: begin
                                    if (wen_q) begin
                                       pg_go_o   <= 1'b1;
                                       pg_kind_o <= PG_ERAL;
                                       pend_q    <= 1'b1;
                                    end
                                 end
                                 default: st_q <= ST_DAT;
                              endcase
                           end
                        endcase
                     end
                  end
                  ST_DAT: begin
                     data_q <= data_n;
                     cnt_q  <= cnt_q + 1'b1;
                     if (cnt_q == d_last) begin
                        st_q <= ST_DONE;
                        if (wen_q && pe_s) begin
                           pg_go_o   <= 1'b1;
                           pg_kind_o <= (op_q == OPC_WRITE) ? PG_WORD : PG_WRAL;
                           pg_data_o <= data_n;
                           pend_q    <= 1'b1;
                        end
                     end
                  end
                  ST_RD: begin
                     rd_bit_o <= sr_q[15];
                     sr_q     <= {sr_q[14:0], 1'b0};
                     cnt_q    <= cnt_q + 1'b1;
                     if (cnt_q == d_last) begin
                        cnt_q  <= '0;
                        addr_q <= addr_inc;
                        sr_q   <= rq_i;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
   import mw_pkg::*;
#(
   parameter int ADDR16_W = 10,
   parameter int PROG_CYC = 5000,
   parameter int SYNC_STG = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   input  logic org_i,
   input  logic pe_i,
   output logic do_o,
   output logic do_oe
);

   if (ADDR16_W < 2) begin : g_bad_aw
      $error("ADDR16_W must be at least 2 for the sub-opcode field");
   end
   if (PROG_CYC < 1) begin : g_bad_cyc
      $error("PROG_CYC must be at least 1");
   end

   logic [4:0]          pins_s;
   logic                cs_s, sk_s, di_s, org_s, pe_s;
   logic                sk_q;
   logic                sk_rise;
   logic                busy;
   logic                prog_go;
   mw_prog_e            prog_kind;
   logic [ADDR16_W:0]   prog_addr;
   logic [15:0]         prog_data;
   logic                prog_org;
   logic [ADDR16_W:0]   rd_addr;
   logic                rd_org;
   logic [15:0]         rd_word;
   logic                rd_oe;
   logic                rd_bit;
   logic                stat_show;
   logic                wen_q;

   mw_sync #(.W(5), .STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_i, sk_i, di_i, org_i, pe_i}),
      .q_o   (pins_s)
   );

   assign {cs_s, sk_s, di_s, org_s, pe_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_q <= 1'b0;
      else        sk_q <= sk_s;
   end

   assign sk_rise = sk_s & ~sk_q & cs_s;

   mw_cmd_ctrl #(.ADDR16_W(ADDR16_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sk_rise   (sk_rise),
      .di_s      (di_s),
      .org_s     (org_s),
      .pe_s      (pe_s),
      .busy_i    (busy),
      .rq_i      (rd_word),
      .ra_o      (rd_addr),
      .rorg_o    (rd_org),
      .pg_go_o   (prog_go),
      .pg_kind_o (prog_kind),
      .pg_addr_o (prog_addr),
      .pg_data_o (prog_data),
      .pg_org_o  (prog_org),
      .rd_oe_o   (rd_oe),
      .rd_bit_o  (rd_bit),
      .show_o    (stat_show),
      .wen_o     (wen_q)
   );

   mw_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (prog_go),
      .busy_o (busy)
   );

   mw_store #(.ADDR16_W(ADDR16_W)) u_store (
      .clk    (clk),
      .go_i   (prog_go),
      .kind_i (prog_kind),
      .wa_i   (prog_addr),
      .wd_i   (prog_data),
      .worg_i (prog_org),
      .ra_i   (rd_addr),
      .rorg_i (rd_org),
      .rq_o   (rd_word)
   );

   assign do_oe = rd_oe | stat_show;
   assign do_o  = rd_oe ? rd_bit : ~busy;

endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker #(
   parameter int PROG_CYC = 5000
) (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic busy,
   input logic prog_go,
   input logic wen,
   input logic do_oe
);

   localparam int RW = $clog2(PROG_CYC + 2);

   logic [RW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_len <= '0;
      else if (busy)  run_len <= run_len + 1'b1;
      else            run_len <= '0;
   end

   a_r10_oe_off_when_deselected: assert property (
      @(posedge clk) disable iff (!rst_n) !cs_s |=> !do_oe);

   a_r8_busy_length: assert property (
      @(posedge clk) disable iff (!rst_n) $fell(busy) |-> (run_len == RW'(PROG_CYC)));

   a_r8_busy_follows_start: assert property (
      @(posedge clk) disable iff (!rst_n) prog_go |=> busy);

   a_r9_no_start_while_busy: assert property (
      @(posedge clk) disable iff (!rst_n) busy |-> !prog_go);

   a_r4_start_needs_latch: assert property (
      @(posedge clk) disable iff (!rst_n) prog_go |-> $past(wen));

endmodule

bind mw_eeprom_slave mw_eeprom_checker #(.PROG_CYC(PROG_CYC)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_s    (cs_s),
   .busy    (busy),
   .prog_go (prog_go),
   .wen     (wen_q),
   .do_oe   (do_oe)
);

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;

   localparam int AW16  = 4;
   localparam int WORDS = 1 << AW16;
   localparam int PCYC  = 600;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1, pe = 1'b1;
   logic do_o, do_oe;

   int n_chk = 0;
   int n_err = 0;
   logic [15:0] m [WORDS];

   always #5 clk = ~clk;

   mw_eeprom_slave #(.ADDR16_W(AW16), .PROG_CYC(PCYC)) i_mw_eeprom_slave (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
      .org_i(org), .pe_i(pe), .do_o(do_o), .do_oe(do_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b, output logic o, output logic oe);
      di = b;
      repeat (4) @(negedge clk);
      sk = 1'b1;
      repeat (4) @(negedge clk);
      o  = do_o;
      oe = do_oe;
      sk = 1'b0;
   endtask

   task automatic send(input logic [31:0] v, input int n);
      logic o, oe;
      for (int i = n - 1; i >= 0; i--) clk_bit(v[i], o, oe);
   endtask

   task automatic cs_up();
      cs = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic cs_down();
      cs = 1'b0;
      di = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   function automatic int awid(input logic o16);
      return o16 ? AW16 : AW16 + 1;
   endfunction

   function automatic logic [15:0] exp_rd(input logic o16, input int a);
      if (o16) return m[a % WORDS];
      a = a % (2 * WORDS);
      return a[0] ? {8'h00, m[a >> 1][15:8]} : {8'h00, m[a >> 1][7:0]};
   endfunction

   // status must show busy then ready (R8, R10)
   task automatic wait_ready(input string req);
      int t;
      cs_up();
      repeat (2) @(negedge clk);
      check({req, " R10 busy flag"}, {30'd0, do_oe, do_o}, 32'd2);
      t = 0;
      while (do_o !== 1'b1 && t < PCYC + 100) begin
         @(negedge clk);
         t++;
      end
      check({req, " R8 ready reached"}, {31'd0, do_o}, 32'd1);
      cs_down();
   endtask

   // no programming cycle may have started
   task automatic no_prog(input string req);
      cs_up();
      repeat (2) @(negedge clk);
      check({req, " no cycle"}, {31'd0, do_oe}, 32'd0);
      cs_down();
   endtask

   task automatic rd_run(input string req, input logic o16, input int a0, input int n);
      logic o, oe;
      logic [15:0] got;
      int dw;
      dw = o16 ? 16 : 8;
      org = o16;
      cs_up();
      send({30'd0, 2'b10} | 32'h4, 3);
      for (int i = awid(o16) - 1; i >= 0; i--) clk_bit(a0[i], o, oe);
      check({req, " R5 dummy zero"}, {30'd0, oe, o}, 32'd2);
      for (int k = 0; k < n; k++) begin
         got = '0;
         for (int b = 0; b < dw; b++) begin
            clk_bit(1'b0, o, oe);
            got = {got[14:0], o};
         end
         check({req, " R6 read word"}, {16'd0, got}, {16'd0, exp_rd(o16, a0 + k)});
      end
      cs_down();
   endtask

   task automatic cmd_ext(input logic o16, input logic [1:0] sub);
      int aw;
      aw = awid(o16);
      org = o16;
      cs_up();
      send(32'b100, 3);
      send({30'd0, sub} << (aw - 2), aw);
      cs_down();
   endtask

   task automatic cmd_wr(input logic o16, input int a, input logic [15:0] d);
      org = o16;
      cs_up();
      send(32'b101, 3);
      send(a, awid(o16));
      send({16'd0, d}, o16 ? 16 : 8);
      cs_down();
   endtask

   task automatic cmd_erase(input logic o16, input int a);
      org = o16;
      cs_up();
      send(32'b111, 3);
      send(a, awid(o16));
      cs_down();
   endtask

   task automatic cmd_wral(input logic o16, input logic [15:0] d);
      int aw;
      aw = awid(o16);
      org = o16;
      cs_up();
      send(32'b100, 3);
      send(32'b01 << (aw - 2), aw);
      send({16'd0, d}, o16 ? 16 : 8);
      cs_down();
   endtask

   initial begin
      repeat (100_000) @(negedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic o, oe;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 reset oe", {31'd0, do_oe}, 32'd0);

      // R4: programming commands rejected while latch is clear after reset
      cmd_ext(1'b1, 2'b10);
      no_prog("R4 eral before enable");

      // R1: idle clocks with di low, then enable, all in one select period
      cs_up();
      for (int i = 0; i < 5; i++) clk_bit(1'b0, o, oe);
      check("R1 noise ignored", {31'd0, oe}, 32'd0);
      send(32'b100, 3);
      send(32'b1100, 4);
      cs_down();

      // R7: erase all
      cmd_ext(1'b1, 2'b10);
      for (int i = 0; i < WORDS; i++) m[i] = 16'hFFFF;
      wait_ready("R7 eral");
      rd_run("R7 eral contents", 1'b1, 0, WORDS + 1);

      // R4: disable then attempt write; R5 read still works
      cmd_ext(1'b1, 2'b00);
      cmd_wr(1'b1, 3, 16'hA5A5);
      no_prog("R4 write disabled");
      rd_run("R4 word unchanged", 1'b1, 3, 1);

      // R2, R3: write sweep in 16-bit mode
      cmd_ext(1'b1, 2'b11);
      for (int a = 0; a < WORDS; a++) begin
         m[a] = 16'(a * 16'h1357) ^ 16'h0F3C;
         cmd_wr(1'b1, a, m[a]);
         wait_ready("R2 write");
      end
      rd_run("R2 sweep x16", 1'b1, 0, WORDS);
      rd_run("R6 wrap x16", 1'b1, WORDS - 2, 4);

      // R3: byte view of the same storage, with wrap
      rd_run("R3 sweep x8", 1'b0, 0, 2 * WORDS);
      rd_run("R6 wrap x8", 1'b0, 2 * WORDS - 1, 3);

      // R3: byte write to odd address lands in upper half
      cmd_wr(1'b0, 9, 16'h005A);
      m[4][15:8] = 8'h5A;
      wait_ready("R3 byte write");
      rd_run("R3 lane check", 1'b1, 4, 1);

      // R7: word and byte erase
      cmd_erase(1'b1, 7);
      m[7] = 16'hFFFF;
      wait_ready("R7 erase");
      cmd_erase(1'b0, 4);
      m[2][7:0] = 8'hFF;
      wait_ready("R7 byte erase");
      rd_run("R7 erase contents", 1'b1, 0, WORDS);

      // R11: program enable low blocks write and write-all
      pe = 1'b0;
      cmd_wr(1'b1, 1, 16'h1234);
      no_prog("R11 write blocked");
      cmd_wral(1'b1, 16'h0000);
      no_prog("R11 wral blocked");
      pe = 1'b1;
      rd_run("R11 contents kept", 1'b1, 0, WORDS);

      // R12: abandoned partial write
      org = 1'b1;
      cs_up();
      send(32'b101, 3);
      send(32'b11, 2);
      cs_down();
      no_prog("R12 partial");
      rd_run("R12 contents kept", 1'b1, 0, WORDS);

      // R9, R10: command during busy is ignored; start bit clears flag
      cmd_wr(1'b1, 10, 16'hBEEF);
      m[10] = 16'hBEEF;
      cs_up();
      repeat (2) @(negedge clk);
      check("R10 busy during cycle", {30'd0, do_oe, do_o}, 32'd2);
      cs_down();
      cmd_wr(1'b1, 11, 16'h1111);
      cs_up();
      repeat (2) @(negedge clk);
      while (do_o !== 1'b1) @(negedge clk);
      check("R10 ready shown", {30'd0, do_oe, do_o}, 32'd3);
      clk_bit(1'b1, o, oe);
      check("R10 start removes flag", {31'd0, oe}, 32'd0);
      cs_down();
      rd_run("R9 ignored write", 1'b1, 10, 2);

      // R7: write-all in both organizations
      cmd_wral(1'b1, 16'hC33C);
      for (int i = 0; i < WORDS; i++) m[i] = 16'hC33C;
      wait_ready("R7 wral x16");
      rd_run("R7 wral x16 contents", 1'b1, 0, WORDS);
      cmd_wral(1'b0, 16'h0069);
      for (int i = 0; i < WORDS; i++) m[i] = 16'h6969;
      wait_ready("R7 wral x8");
      rd_run("R7 wral x8 contents", 1'b1, 0, WORDS);

      check("R10 deselected oe", {31'd0, do_oe}, 32'd0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule